// File: doc/BRIEF.md
# Host Interrupt Status Controller

This block gathers single-cycle event pulses from a storage-card host's command path, data path, DMA engine and card-detect logic into one status word. A latch-enable mask picks which events are captured. A second mask, the signal-enable mask, picks which captured bits drive the single interrupt line. Software clears status bits by writing ones to them. It can also inject error conditions through a write-only force register, so that error handlers can be tested without a faulty card.

When the automatic stop command at the end of a multi-block transfer fails, one summary status bit is set. The detailed reason is held in a separate readable cause register. Two combinational summary outputs tell the surrounding logic whether any command-line error or any data-line error is pending.

Register access uses a simple port. A write takes effect at the clock edge while `reg_we` is high. Reads are combinational from `reg_addr`. Register addresses: 0 status, 1 latch-enable, 2 signal-enable, 3 force (write-only), 4 stop cause (read-only). Any other address reads as zero.

Top module: `hirq_top`

## Requirements
- R1: After reset, status, latch-enable, signal-enable and stop cause all read 0, and `irq_o`, `cmd_err_any_o` and `data_err_any_o` are 0.
- R2: An `evt_i` pulse on an implemented bit whose latch-enable bit is 1 sets that status bit at the next clock edge. The bit stays set until it is cleared. Bit positions: 0 command done, 1 transfer done, 2 block gap, 3 DMA done, 4 buffer write ready, 5 buffer read ready, 6 card inserted, 7 card removed, 8 card interrupt, 16 command timeout, 17 command CRC, 18 command end bit, 19 command index, 20 data timeout, 21 data CRC, 22 data end bit, 23 auto-stop failure, 24 DMA error.
- R3: An event whose latch-enable bit is 0 has no effect on status.
- R4: Writing the status address clears every status bit written as 1 and leaves every bit written as 0 unchanged.
- R5: An event that arrives in the same cycle as a write-one-to-clear of its own bit leaves the bit set.
- R6: `irq_o` is high exactly one cycle after (status AND signal-enable) is nonzero. It follows that value one cycle late. The signal-enable mask has no effect on which bits are latched.
- R7: A write to the force address acts like events on the error bits written as 1 (bits 16 to 24). Force bits 0 to 5 are auto-stop sub-causes, and any of them acts like an event on bit 23. All other force bits are ignored. The force address reads as 0, and forced events obey the latch-enable mask.
- R8: When bit 23 is latched, the stop cause register is loaded with the `stop_cause_i` value (if the `evt_i` bit 23 pulse is present) ORed with the forced sub-cause bits 0 to 5 (0 not executed, 1 timeout, 2 CRC, 3 end bit, 4 index, 5 command not issued). If bit 23 is not latched, the cause register keeps its value.
- R9: `cmd_err_any_o` is the OR of status bits 16 to 19. `data_err_any_o` is the OR of status bits 20 to 22.
- R10: Status bits and mask bits at positions not listed in R2 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| evt_i | input | 32 | Event pulses, one bit per status position |
| stop_cause_i | input | 6 | Auto-stop failure sub-cause, valid with evt_i[23] |
| irq_o | output | 1 | Registered interrupt request |
| cmd_err_any_o | output | 1 | Any command error pending |
| data_err_any_o | output | 1 | Any data error pending |

## Verification
The bench uses the default configuration: a 32-bit status word, a 3-bit address and a 6-bit cause field. At this size every one of the 32 status positions can be swept. Each bit is pulsed, masked, forced and routed to the interrupt in turn, so the implemented-bit map, the reserved holes and the force decoding are checked bit by bit. Expected values are built from the bit-position list in the requirements. The collision of a set and a clear, and the one-cycle lag of the interrupt after a clear, are also driven.

// File: rtl/hirq_pkg.sv
package hirq_pkg;
  localparam int STAT_W  = 32;
  localparam int ADDR_W  = 3;
  localparam int CAUSE_W = 6;

  localparam int B_CMD_DONE  = 0;
  localparam int B_XFER_DONE = 1;
  localparam int B_GAP       = 2;
  localparam int B_DMA_DONE  = 3;
  localparam int B_BUF_WR    = 4;
  localparam int B_BUF_RD    = 5;
  localparam int B_CARD_IN   = 6;
  localparam int B_CARD_OUT  = 7;
  localparam int B_CARD_IRQ  = 8;
  localparam int B_CMD_TO    = 16;
  localparam int B_CMD_CRC   = 17;
  localparam int B_CMD_END   = 18;
  localparam int B_CMD_IDX   = 19;
  localparam int B_DAT_TO    = 20;
  localparam int B_DAT_CRC   = 21;
  localparam int B_DAT_END   = 22;
  localparam int B_STOP_ERR  = 23;
  localparam int B_DMA_ERR   = 24;

  localparam logic [STAT_W-1:0] NORMAL_MASK =
    (STAT_W'(1) << (B_CARD_IRQ + 1)) - STAT_W'(1);
  localparam logic [STAT_W-1:0] CMD_ERR_MASK =
    (STAT_W'(1) << B_CMD_TO) | (STAT_W'(1) << B_CMD_CRC) |
    (STAT_W'(1) << B_CMD_END) | (STAT_W'(1) << B_CMD_IDX);
  localparam logic [STAT_W-1:0] DATA_ERR_MASK =
    (STAT_W'(1) << B_DAT_TO) | (STAT_W'(1) << B_DAT_CRC) |
    (STAT_W'(1) << B_DAT_END);
  localparam logic [STAT_W-1:0] FORCE_ERR_MASK =
    CMD_ERR_MASK | DATA_ERR_MASK |
    (STAT_W'(1) << B_STOP_ERR) | (STAT_W'(1) << B_DMA_ERR);
  localparam logic [STAT_W-1:0] IMPL_MASK = NORMAL_MASK | FORCE_ERR_MASK;

  typedef enum logic [ADDR_W-1:0] {
    A_STATUS = 3'd0,
    A_LATCH  = 3'd1,
    A_SIGNAL = 3'd2,
    A_FORCE  = 3'd3,
    A_CAUSE  = 3'd4
  } reg_addr_e;

  // Clear-then-set: a set in the same cycle wins over a clear.
  function automatic logic [STAT_W-1:0] w1c_update(
      input logic [STAT_W-1:0] cur,
      input logic [STAT_W-1:0] set,
      input logic [STAT_W-1:0] clr);
    return (cur & ~clr) | set;
  endfunction

  // Decodes a force word into status set requests.
  function automatic logic [STAT_W-1:0] force_to_set(
      input logic [STAT_W-1:0] fw);
    logic [STAT_W-1:0] s;
    s = fw & FORCE_ERR_MASK;
    if (|fw[CAUSE_W-1:0]) s[B_STOP_ERR] = 1'b1;
    return s;
  endfunction

  function automatic logic any_in(
      input logic [STAT_W-1:0] v,
      input logic [STAT_W-1:0] mask);
    return |(v & mask);
  endfunction
endpackage

// File: rtl/hirq_regs.sv
module hirq_regs
  import hirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [STAT_W-1:0] wdata,
  output logic [STAT_W-1:0] latch_en_o,
  output logic [STAT_W-1:0] sig_en_o,
  output logic [STAT_W-1:0] clr_o,
  output logic [STAT_W-1:0] force_set_o,
  output logic [CAUSE_W-1:0] force_cause_o
);
  logic wr_status, wr_latch, wr_signal, wr_force;
  logic [STAT_W-1:0] latch_q, sig_q;

  assign wr_status = wr_en && (addr == A_STATUS);
  assign wr_latch  = wr_en && (addr == A_LATCH);
  assign wr_signal = wr_en && (addr == A_SIGNAL);
  assign wr_force  = wr_en && (addr == A_FORCE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      sig_q   <= '0;
    end else begin
      if (wr_latch)  latch_q <= wdata & IMPL_MASK;
      if (wr_signal) sig_q   <= wdata & IMPL_MASK;
    end
  end

  assign latch_en_o    = latch_q;
  assign sig_en_o      = sig_q;
  assign clr_o         = wr_status ? wdata : '0;
  assign force_set_o   = wr_force ? force_to_set(wdata) : '0;
  assign force_cause_o = wr_force ? wdata[CAUSE_W-1:0] : '0;
endmodule

// File: rtl/hirq_status.sv
module hirq_status
  import hirq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STAT_W-1:0]  evt,
  input  logic [CAUSE_W-1:0] hw_cause,
  input  logic [STAT_W-1:0]  force_set,
  input  logic [CAUSE_W-1:0] force_cause,
  input  logic [STAT_W-1:0]  latch_en,
  input  logic [STAT_W-1:0]  clr,
  output logic [STAT_W-1:0]  set_vec_o,
  output logic               stop_accept_o,
  output logic [STAT_W-1:0]  status_o,
  output logic [CAUSE_W-1:0] cause_o
);
  logic [STAT_W-1:0]  raw_evt;
  logic [STAT_W-1:0]  status_q;
  logic [CAUSE_W-1:0] cause_q, cause_d;

  assign raw_evt       = (evt | force_set) & IMPL_MASK;
  assign set_vec_o     = raw_evt & latch_en;
  assign stop_accept_o = set_vec_o[B_STOP_ERR];
  assign cause_d       = (evt[B_STOP_ERR] ? hw_cause : '0) | force_cause;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      cause_q  <= '0;
    end else begin
      status_q <= w1c_update(status_q, set_vec_o, clr);
      if (stop_accept_o) cause_q <= cause_d;
    end
  end

  assign status_o = status_q;
  assign cause_o  = cause_q;
endmodule

// File: rtl/hirq_irq.sv
module hirq_irq
  import hirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] status,
  input  logic [STAT_W-1:0] sig_en,
  output logic              irq_o,
  output logic              cmd_any_o,
  output logic              data_any_o
);
  logic irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= any_in(status, sig_en);
  end

  assign irq_o      = irq_q;
  assign cmd_any_o  = any_in(status, CMD_ERR_MASK);
  assign data_any_o = any_in(status, DATA_ERR_MASK);
endmodule

// File: rtl/hirq_top.sv
module hirq_top
  import hirq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [STAT_W-1:0]  reg_wdata,
  output logic [STAT_W-1:0]  reg_rdata,
  input  logic [STAT_W-1:0]  evt_i,
  input  logic [CAUSE_W-1:0] stop_cause_i,
  output logic               irq_o,
  output logic               cmd_err_any_o,
  output logic               data_err_any_o
);
  logic [STAT_W-1:0]  latch_en, sig_en, clr_vec, force_set, set_vec, status_q;
  logic [CAUSE_W-1:0] force_cause, cause_q;
  logic               stop_accept;

  hirq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .latch_en_o(latch_en), .sig_en_o(sig_en),
    .clr_o(clr_vec), .force_set_o(force_set), .force_cause_o(force_cause)
  );

  hirq_status u_status (
    .clk(clk), .rst_n(rst_n), .evt(evt_i), .hw_cause(stop_cause_i),
    .force_set(force_set), .force_cause(force_cause), .latch_en(latch_en),
    .clr(clr_vec), .set_vec_o(set_vec), .stop_accept_o(stop_accept),
    .status_o(status_q), .cause_o(cause_q)
  );

  hirq_irq u_irq (
    .clk(clk), .rst_n(rst_n), .status(status_q), .sig_en(sig_en),
    .irq_o(irq_o), .cmd_any_o(cmd_err_any_o), .data_any_o(data_err_any_o)
  );

  always_comb begin
    unique case (reg_addr)
      A_STATUS: reg_rdata = status_q;
      A_LATCH:  reg_rdata = latch_en;
      A_SIGNAL: reg_rdata = sig_en;
      A_CAUSE:  reg_rdata = {{(STAT_W-CAUSE_W){1'b0}}, cause_q};
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/hirq_chk.sv
module hirq_chk
  import hirq_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               reg_we,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [STAT_W-1:0]  reg_wdata,
  input logic [STAT_W-1:0]  set_vec,
  input logic [STAT_W-1:0]  status_q,
  input logic [STAT_W-1:0]  latch_en,
  input logic [STAT_W-1:0]  sig_en,
  input logic               stop_accept,
  input logic [CAUSE_W-1:0] cause_q,
  input logic               irq_o
);
  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(set_vec)) == $past(set_vec))) else $error("set lost"); // R5

  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(latch_en)) == '0)) else $error("unmasked latch"); // R3

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_STATUS)
      |=> ((status_q & $past(reg_wdata) & ~$past(set_vec)) == '0)) else $error("clear missed"); // R4

  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(|(status_q & sig_en)))) else $error("irq timing"); // R6

  AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_accept |=> $stable(cause_q)) else $error("cause moved"); // R8

  always_comb begin
    if (rst_n) begin
      AST_NO_RESERVED: assert ((status_q & ~IMPL_MASK) == '0) else $error("reserved set"); // R10
    end
  end
endmodule

bind hirq_top hirq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .set_vec(set_vec), .status_q(status_q),
  .latch_en(latch_en), .sig_en(sig_en), .stop_accept(stop_accept),
  .cause_q(cause_q), .irq_o(irq_o)
);

// File: tb/hirq_top_tb.sv
module hirq_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] IMPL = 32'h01FF_01FF;
  localparam logic [31:0] CMDM = 32'h000F_0000;
  localparam logic [31:0] DATM = 32'h0070_0000;
  localparam logic [31:0] FERR = 32'h01FF_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] evt_i = '0;
  logic [5:0] stop_cause_i = '0;
  logic irq_o, cmd_err_any_o, data_err_any_o;
  int checks = 0;
  int errors = 0;
  logic [31:0] rv;
  logic [5:0] exp_cause;

  always #(CLK_PERIOD/2) clk = ~clk;

  hirq_top u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_i(evt_i),
    .stop_cause_i(stop_cause_i), .irq_o(irq_o),
    .cmd_err_any_o(cmd_err_any_o), .data_err_any_o(data_err_any_o)
  );

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic pulse(input logic [31:0] v, input logic [5:0] c);
    evt_i = v; stop_cause_i = c;
    tick();
    evt_i = '0; stop_cause_i = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(3'd0, rv); chk("R1 status", rv, 0);
    rd(3'd1, rv); chk("R1 latch", rv, 0);
    rd(3'd2, rv); chk("R1 signal", rv, 0);
    rd(3'd4, rv); chk("R1 cause", rv, 0);
    chk("R1 irq", {31'd0, irq_o}, 0);
    chk("R1 sums", {30'd0, cmd_err_any_o, data_err_any_o}, 0);

    // R3 nothing latched with masks zero
    pulse(32'hFFFF_FFFF, 6'h3F);
    rd(3'd0, rv); chk("R3 all masked", rv, 0);

    // R10 mask readback
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, rv); chk("R10 latch readback", rv, IMPL);

    // R2 R9 R4 R10 per-bit sweep
    for (int i = 0; i < 32; i++) begin
      logic [31:0] e;
      e = IMPL & (32'd1 << i);
      pulse(32'd1 << i, 6'd0);
      rd(3'd0, rv); chk($sformatf("R2 bit %0d", i), rv, e);
      chk($sformatf("R9 cmd bit %0d", i), {31'd0, cmd_err_any_o}, {31'd0, |(e & CMDM)});
      chk($sformatf("R9 data bit %0d", i), {31'd0, data_err_any_o}, {31'd0, |(e & DATM)});
      wr(3'd0, 32'd1 << i);
      rd(3'd0, rv); chk($sformatf("R4 clear bit %0d", i), rv, 0);
    end

    // R4 zeros leave bits, partial clear
    pulse(32'h0010_0001, 6'd0);
    wr(3'd0, 32'h0);
    rd(3'd0, rv); chk("R4 zero write", rv, 32'h0010_0001);
    wr(3'd0, 32'h0000_0001);
    rd(3'd0, rv); chk("R4 partial clear", rv, 32'h0010_0000);
    wr(3'd0, 32'hFFFF_FFFF);

    // R3 per-bit latch disable
    for (int i = 0; i < 32; i++) begin
      wr(3'd1, ~(32'd1 << i));
      pulse(32'hFFFF_FFFF, 6'd0);
      rd(3'd0, rv); chk($sformatf("R3 mask bit %0d", i), rv, IMPL & ~(32'd1 << i));
      wr(3'd0, 32'hFFFF_FFFF);
    end
    wr(3'd1, 32'hFFFF_FFFF);

    // R5 set wins over clear
    evt_i = 32'h0000_0044;
    wr(3'd0, 32'h0000_0004);
    evt_i = '0;
    rd(3'd0, rv); chk("R5 set wins", rv, 32'h0000_0044);
    wr(3'd0, 32'hFFFF_FFFF);

    // R6 interrupt routing sweep
    pulse(32'hFFFF_FFFF, 6'd0);
    wr(3'd2, 32'h0);
    tick();
    chk("R6 no signal enable", {31'd0, irq_o}, 0);
    for (int i = 0; i < 32; i++) begin
      wr(3'd2, 32'd1 << i);
      tick();
      chk($sformatf("R6 irq bit %0d", i), {31'd0, irq_o}, {31'd0, IMPL[i]});
    end
    wr(3'd2, 32'h1);
    tick();
    wr(3'd0, 32'hFFFF_FFFF);
    chk("R6 irq lag after clear", {31'd0, irq_o}, 1);
    tick();
    chk("R6 irq low after clear", {31'd0, irq_o}, 0);
    pulse(32'h1, 6'd0);
    chk("R6 irq not yet", {31'd0, irq_o}, 0);
    tick();
    chk("R6 irq rises", {31'd0, irq_o}, 1);
    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd2, 32'h0);
    rd(3'd1, rv); chk("R6 signal mask leaves latch", rv, IMPL);

    // R7 R8 force sweep
    exp_cause = 6'd0;
    for (int j = 0; j < 32; j++) begin
      logic [31:0] e;
      e = FERR & (32'd1 << j);
      if (j < 6) e[23] = 1'b1;
      if (e[23]) exp_cause = (j < 6) ? 6'(1 << j) : 6'd0;
      wr(3'd3, 32'd1 << j);
      rd(3'd0, rv); chk($sformatf("R7 force bit %0d", j), rv, e);
      rd(3'd4, rv); chk($sformatf("R8 force cause %0d", j), rv, {26'd0, exp_cause});
      rd(3'd3, rv); chk("R7 force reads zero", rv, 0);
      wr(3'd0, 32'hFFFF_FFFF);
    end

    // R7 forced events obey latch mask
    wr(3'd1, IMPL & ~FERR);
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd0, rv); chk("R7 force masked", rv, 0);
    rd(3'd4, rv); chk("R8 cause held when masked", rv, {26'd0, exp_cause});

    // R8 hardware cause
    pulse(32'h0080_0000, 6'h2A);
    rd(3'd4, rv); chk("R8 cause held hw masked", rv, {26'd0, exp_cause});
    wr(3'd1, 32'hFFFF_FFFF);
    pulse(32'h0080_0000, 6'h2A);
    rd(3'd0, rv); chk("R8 stop status", rv, 32'h0080_0000);
    rd(3'd4, rv); chk("R8 hw cause", rv, 32'h2A);
    evt_i = 32'h0080_0000; stop_cause_i = 6'h01;
    wr(3'd3, 32'h0000_0010);
    evt_i = '0; stop_cause_i = '0;
    rd(3'd4, rv); chk("R8 hw or forced cause", rv, 32'h11);
    rd(3'd7, rv); chk("R10 unused address", rv, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule